// File: doc/BRIEF.md
# Direct-Mapped Write-Through Word Cache Controller

This controller sits between a 16-bit asynchronous-style CPU bus and a slow main memory. It holds a direct-mapped store of 16-bit words. Each entry carries a valid bit and the upper address bits as a tag. Every CPU write is passed on to main memory. A full-word write to a cacheable address also places the word and its tag in the store. A read that finds a valid, matching entry is answered from the store after one wait state, and no main-memory cycle is started. A read miss is served by main memory and leaves the store unchanged.

Cacheability is decided by fixed address windows. A jumper-style input can remove part of one window so that hardware with bus-mastering ability can use it safely. Caching stays off after reset until an auto-configuration start pulse arrives while the enable switch is on. Reset and any bus-master (DMA) activity clear every valid bit in the same cycle, so nothing stale survives a memory change the controller could not observe.

The CPU bus is modelled synchronously. The bus master raises the address strobe with address, direction, byte strobes and write data, and holds all of them stable until the acknowledge appears. It then drops the strobe.

Top module: `wt_cache_ctrl`

## Requirements
- R1: While rst_ni is low and on the first cycle after it rises, cpu_dtack_o and mem_req_o are low. Reset clears all valid bits and turns caching off.
- R2: Caching is off until a cycle with autocfg_i and cache_sw_i both high. An autocfg_i pulse with cache_sw_i low leaves caching off. While caching is off, every access goes to main memory.
- R3: Every write, cacheable or not, raises mem_req_o with mem_we_o high and carries the write address, data and byte strobes to main memory. cpu_dtack_o rises only after mem_ack_i.
- R4: A cacheable write with both strobes high (cpu_uds_i and cpu_lds_i) stores the word. A later read of the same address hits: cpu_dtack_o is high at the first sample after the edge that sees the strobe, mem_req_o stays low, and cpu_rdata_o returns the stored word.
- R5: A read miss raises mem_req_o, returns mem_rdata_i captured at mem_ack_i, and allocates nothing, so repeating the read misses again.
- R6: The index is cpu_addr_i[INDEX_W:1] and the tag is cpu_addr_i[23:INDEX_W+1]. Addresses that differ by a multiple of 2^(INDEX_W+1) bytes share one entry. The default INDEX_W is 8, so the stride is 0x200. A full write to one address evicts the other.
- R7: A cacheable write with only one byte strobe high goes to memory and invalidates the entry at its index. The next read of that word misses.
- R8: A cycle with dma_i high clears every valid bit. If a store write happens in the same cycle, the clear wins.
- R9: The cacheable windows are 0x200000–0x9FFFFF, 0xC00000–0xD8FFFF and 0xF80000–0xFFFFFF. Addresses outside them never hit.
- R10: When option_i is low, 0x600000–0x9FFFFF is not cacheable.
- R11: Once raised, cpu_dtack_o stays high while cpu_as_i stays high. It is low on the cycle after cpu_as_i is seen low.

Default parameters: INDEX_W=8, giving a 256-word store. A full-size 8K-word store uses INDEX_W=13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_as_i | input | 1 | CPU address strobe, high = bus cycle active |
| cpu_uds_i | input | 1 | Upper byte strobe (data bits 15:8) |
| cpu_lds_i | input | 1 | Lower byte strobe (data bits 7:0) |
| cpu_rw_i | input | 1 | 1 = read, 0 = write |
| cpu_addr_i | input | 24 | Byte address, bit 0 unused |
| cpu_wdata_i | input | 16 | CPU write data |
| cpu_rdata_o | output | 16 | Read data to CPU |
| cpu_dtack_o | output | 1 | Data acknowledge to CPU |
| mem_req_o | output | 1 | Main-memory cycle request |
| mem_we_o | output | 1 | Main-memory write |
| mem_addr_o | output | 24 | Main-memory word address (bit 0 zero) |
| mem_uds_o | output | 1 | Upper byte strobe to memory |
| mem_lds_o | output | 1 | Lower byte strobe to memory |
| mem_wdata_o | output | 16 | Write data to memory |
| mem_rdata_i | input | 16 | Read data from memory |
| mem_ack_i | input | 1 | Memory cycle complete |
| dma_i | input | 1 | Bus-master activity, flushes the cache |
| option_i | input | 1 | Low removes 0x600000–0x9FFFFF from the cacheable set |
| cache_sw_i | input | 1 | Enable switch, sampled at autocfg_i |
| autocfg_i | input | 1 | Auto-configuration start pulse |

## Verification
The assertions assume that the CPU holds direction, address and strobes steady from strobe assertion until acknowledge. They also assume the strobe stays high throughout a memory cycle and that mem_ack_i comes only while a request is pending. The bench drives all inputs on the falling clock edge and keeps every access open until it has seen the acknowledge. Its memory model raises mem_ack_i for exactly one cycle, two cycles into each request, and only while mem_req_o is high.

// File: rtl/wt_cache_pkg.sv
package wt_cache_pkg;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIT  = 2'd1,
    ST_MEM  = 2'd2,
    ST_DONE = 2'd3
  } cc_state_e;

  localparam logic [ADDR_W-1:0] WIN_LO_BASE = 24'h200000;
  localparam logic [ADDR_W-1:0] WIN_LO_TOP  = 24'h9FFFFF;
  localparam logic [ADDR_W-1:0] WIN_HOLE    = 24'h600000;
  localparam logic [ADDR_W-1:0] WIN_MID_BASE = 24'hC00000;
  localparam logic [ADDR_W-1:0] WIN_MID_TOP  = 24'hD8FFFF;
  localparam logic [ADDR_W-1:0] WIN_HI_BASE  = 24'hF80000;
endpackage

// File: rtl/cc_region.sv
module cc_region
  import wt_cache_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              option_i,
  output logic              cacheable_o
);
  logic in_lo, in_mid, in_hi;

  always_comb begin
    in_lo  = (addr_i >= WIN_LO_BASE) && (addr_i <= WIN_LO_TOP) &&
             (option_i || (addr_i < WIN_HOLE));
    in_mid = (addr_i >= WIN_MID_BASE) && (addr_i <= WIN_MID_TOP);
    in_hi  = (addr_i >= WIN_HI_BASE);
    cacheable_o = in_lo || in_mid || in_hi;
  end
endmodule

// File: rtl/cc_store.sv
module cc_store #(
  parameter int IDX_W = 8,
  parameter int TAG_W = 15,
  parameter int DW    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             wr_i,
  input  logic             inv_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             hit_o,
  output logic [DW-1:0]    rdata_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] valid_q;
  logic [TAG_W-1:0] tag_mem  [DEPTH];
  logic [DW-1:0]    data_mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        valid_q <= '0;
    else if (flush_i)   valid_q <= '0;
    else if (wr_i)      valid_q[idx_i] <= 1'b1;
    else if (inv_i)     valid_q[idx_i] <= 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) begin
      tag_mem[idx_i]  <= tag_i;
      data_mem[idx_i] <= wdata_i;
    end
  end

  assign hit_o   = valid_q[idx_i] && (tag_mem[idx_i] == tag_i);
  assign rdata_o = data_mem[idx_i];
endmodule

// File: rtl/cc_fsm.sv
module cc_fsm
  import wt_cache_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              as_i,
  input  logic              uds_i,
  input  logic              lds_i,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cacheable_i,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] cache_rdata_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i,
  input  logic              cache_sw_i,
  input  logic              autocfg_i,
  output logic              st_wr_o,
  output logic              st_inv_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              dtack_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_uds_o,
  output logic              mem_lds_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  cc_state_e state_q;
  logic en_q, accept, look, fast;
  logic [DATA_W-1:0] rdata_q;

  assign accept   = (state_q == ST_IDLE) && as_i;
  assign look     = accept && en_q && cacheable_i;
  assign fast     = look && rw_i && hit_i;
  assign st_wr_o  = look && !rw_i && uds_i && lds_i;
  assign st_inv_o = look && !rw_i && !(uds_i && lds_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else if (autocfg_i && cache_sw_i) en_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      rdata_q     <= '0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_uds_o   <= 1'b0;
      mem_lds_o   <= 1'b0;
      mem_wdata_o <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (fast) begin
            state_q <= ST_HIT;
            rdata_q <= cache_rdata_i;
          end else begin
            state_q     <= ST_MEM;
            mem_we_o    <= !rw_i;
            mem_addr_o  <= {addr_i[ADDR_W-1:1], 1'b0};
            mem_uds_o   <= uds_i;
            mem_lds_o   <= lds_i;
            mem_wdata_o <= wdata_i;
          end
        end
        ST_MEM: if (mem_ack_i) begin
          state_q <= ST_DONE;
          if (!mem_we_o) rdata_q <= mem_rdata_i;
        end
        ST_HIT, ST_DONE: if (!as_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rdata_o   = rdata_q;
  assign dtack_o   = (state_q == ST_HIT) || (state_q == ST_DONE);
  assign mem_req_o = (state_q == ST_MEM);
endmodule

// File: rtl/wt_cache_ctrl.sv
module wt_cache_ctrl
  import wt_cache_pkg::*;
#(
  parameter int INDEX_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_as_i,
  input  logic              cpu_uds_i,
  input  logic              cpu_lds_i,
  input  logic              cpu_rw_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_dtack_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_uds_o,
  output logic              mem_lds_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i,
  input  logic              dma_i,
  input  logic              option_i,
  input  logic              cache_sw_i,
  input  logic              autocfg_i
);
  localparam int TAG_W = ADDR_W - 1 - INDEX_W;

  logic cacheable, hit, st_wr, st_inv;
  logic [DATA_W-1:0] cache_rdata;

  cc_region u_region (
    .addr_i      (cpu_addr_i),
    .option_i    (option_i),
    .cacheable_o (cacheable)
  );

  cc_store #(.IDX_W(INDEX_W), .TAG_W(TAG_W), .DW(DATA_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (dma_i),
    .idx_i   (cpu_addr_i[INDEX_W:1]),
    .tag_i   (cpu_addr_i[ADDR_W-1:INDEX_W+1]),
    .wr_i    (st_wr),
    .inv_i   (st_inv),
    .wdata_i (cpu_wdata_i),
    .hit_o   (hit),
    .rdata_o (cache_rdata)
  );

  cc_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .as_i          (cpu_as_i),
    .uds_i         (cpu_uds_i),
    .lds_i         (cpu_lds_i),
    .rw_i          (cpu_rw_i),
    .addr_i        (cpu_addr_i),
    .wdata_i       (cpu_wdata_i),
    .cacheable_i   (cacheable),
    .hit_i         (hit),
    .cache_rdata_i (cache_rdata),
    .mem_rdata_i   (mem_rdata_i),
    .mem_ack_i     (mem_ack_i),
    .cache_sw_i    (cache_sw_i),
    .autocfg_i     (autocfg_i),
    .st_wr_o       (st_wr),
    .st_inv_o      (st_inv),
    .rdata_o       (cpu_rdata_o),
    .dtack_o       (cpu_dtack_o),
    .mem_req_o     (mem_req_o),
    .mem_we_o      (mem_we_o),
    .mem_addr_o    (mem_addr_o),
    .mem_uds_o     (mem_uds_o),
    .mem_lds_o     (mem_lds_o),
    .mem_wdata_o   (mem_wdata_o)
  );
endmodule

// File: rtl/wt_cache_ctrl_chk.sv
module wt_cache_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cpu_as_i,
  input logic        cpu_rw_i,
  input logic        cpu_dtack_o,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic        mem_ack_i,
  input logic [23:0] mem_addr_o
);
  p_reset_idle_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!cpu_dtack_o && !mem_req_o));

  // a write is never acknowledged without a memory ack in the cycle before
  p_write_via_mem_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cpu_dtack_o) && !cpu_rw_i) |-> $past(mem_ack_i));

  p_req_dir_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_we_o == !cpu_rw_i));

  p_req_addr_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && $past(mem_req_o)) |-> $stable(mem_addr_o));

  p_no_req_on_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_dtack_o |-> !mem_req_o);

  p_dtack_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_dtack_o && cpu_as_i) |=> cpu_dtack_o);

  p_dtack_release_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_as_i |=> !cpu_dtack_o);
endmodule

bind wt_cache_ctrl wt_cache_ctrl_chk u_chk (.*);

// File: tb/wt_cache_ctrl_test.sv
module wt_cache_ctrl_test;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic as = 0, uds = 0, lds = 0, rw = 1;
  logic [23:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic dtack, mem_req, mem_we, mem_uds, mem_lds;
  logic [23:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic mem_ack = 0, dma = 0, option = 1, sw = 0, autocfg = 0;

  int checks = 0, errors = 0;
  logic [15:0] mem_q [int];
  int wait_cnt = 0;

  always #2.5 clk = ~clk;

  wt_cache_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .cpu_as_i(as), .cpu_uds_i(uds), .cpu_lds_i(lds),
    .cpu_rw_i(rw), .cpu_addr_i(addr), .cpu_wdata_i(wdata), .cpu_rdata_o(rdata),
    .cpu_dtack_o(dtack), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_uds_o(mem_uds), .mem_lds_o(mem_lds), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack), .dma_i(dma), .option_i(option),
    .cache_sw_i(sw), .autocfg_i(autocfg)
  );

  function automatic logic [15:0] mget(input logic [23:0] a);
    int k = int'(a[23:1]);
    return mem_q.exists(k) ? mem_q[k] : (a[16:1] ^ 16'h5A3C);
  endfunction

  // memory model: one-cycle ack two cycles into each request
  always @(negedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (wait_cnt == 1) begin
        wait_cnt = 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          logic [15:0] v;
          v = mget(mem_addr);
          if (mem_uds) v[15:8] = mem_wdata[15:8];
          if (mem_lds) v[7:0]  = mem_wdata[7:0];
          mem_q[int'(mem_addr[23:1])] = v;
        end else mem_rdata <= mget(mem_addr);
      end else wait_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [23:0] a, input logic r, input logic u, input logic l,
                        input logic [15:0] d, output logic [15:0] q,
                        output int lat, output bit used);
    @(negedge clk);
    addr = a; rw = r; uds = u; lds = l; wdata = d; as = 1'b1;
    lat = 0; used = 0;
    do begin
      @(negedge clk);
      lat++;
      if (mem_req) used = 1;
    end while (!dtack && lat < 50);
    q = rdata;
    as = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [23:0] a, input logic [15:0] d, input string req);
    logic [15:0] q; int lat; bit used;
    access(a, 1'b0, 1'b1, 1'b1, d, q, lat, used);
    chk(used && lat > 1 && mget(a) == d, req, "write-through", {15'd0, used, q}, {16'd1, d});
  endtask

  task automatic rd_expect(input logic [23:0] a, input bit exp_hit,
                           input logic [15:0] exp_d, input string req);
    logic [15:0] q; int lat; bit used;
    access(a, 1'b1, 1'b1, 1'b1, 16'h0, q, lat, used);
    if (exp_hit)
      chk(!used && lat == 1 && q == exp_d, req, "read hit", {used, 7'd0, 8'(lat), q}, {8'd0, 8'd1, exp_d});
    else
      chk(used && q == exp_d, req, "read miss", {used, 15'd0, q}, {16'h8000, exp_d});
  endtask

  task automatic t_reset();
    chk(!dtack && !mem_req, "R1", "reset outputs", {dtack, mem_req}, 0);
    @(posedge clk); rst_ni = 1'b1; @(negedge clk);
    chk(!dtack && !mem_req, "R1", "after reset", {dtack, mem_req}, 0);
  endtask

  task automatic t_enable();
    wr(24'h200010, 16'h1111, "R3");
    rd_expect(24'h200010, 0, 16'h1111, "R2");
    @(negedge clk); autocfg = 1; sw = 0; @(negedge clk); autocfg = 0;
    wr(24'h200010, 16'h1112, "R3");
    rd_expect(24'h200010, 0, 16'h1112, "R2");
    sw = 1; autocfg = 1; @(negedge clk); autocfg = 0;
  endtask

  task automatic t_write_hit();
    wr(24'h200020, 16'hBEEF, "R3");
    rd_expect(24'h200020, 1, 16'hBEEF, "R4");
    rd_expect(24'h200020, 1, 16'hBEEF, "R4");
  endtask

  task automatic t_read_miss();
    rd_expect(24'h200040, 0, mget(24'h200040), "R5");
    rd_expect(24'h200040, 0, mget(24'h200040), "R5");
  endtask

  task automatic t_alias();
    wr(24'h200060, 16'h1234, "R3");
    rd_expect(24'h200260, 0, mget(24'h200260), "R6");
    rd_expect(24'h200060, 1, 16'h1234, "R6");
    wr(24'h200260, 16'h5678, "R3");
    rd_expect(24'h200060, 0, 16'h1234, "R6");
    rd_expect(24'h200260, 1, 16'h5678, "R6");
  endtask

  task automatic t_byte();
    logic [15:0] q; int lat; bit used;
    wr(24'h200080, 16'hAAAA, "R3");
    access(24'h200080, 1'b0, 1'b1, 1'b0, 16'h55FF, q, lat, used);
    chk(used && mget(24'h200080) == 16'h55AA, "R7", "byte write merge", mget(24'h200080), 16'h55AA);
    rd_expect(24'h200080, 0, 16'h55AA, "R7");
  endtask

  task automatic t_dma();
    wr(24'h2000A0, 16'hCAFE, "R3");
    @(negedge clk); dma = 1; @(negedge clk); dma = 0;
    rd_expect(24'h2000A0, 0, 16'hCAFE, "R8");
    wr(24'h2000C0, 16'h0F0F, "R3");
    rd_expect(24'h2000C0, 1, 16'h0F0F, "R8");
  endtask

  task automatic win(input logic [23:0] a, input bit cached, input string req);
    wr(a, a[15:0] ^ 16'h3C3C, "R3");
    rd_expect(a, cached, a[15:0] ^ 16'h3C3C, req);
  endtask

  task automatic t_windows();
    win(24'hF80000, 1, "R9"); win(24'hFFFFFE, 1, "R9");
    win(24'hC00000, 1, "R9"); win(24'hD8FFFE, 1, "R9");
    win(24'hD90000, 0, "R9"); win(24'h9FFFFE, 1, "R9");
    win(24'hA00000, 0, "R9"); win(24'h1FFFFE, 0, "R9");
    win(24'h200000, 1, "R9"); win(24'hBFFFFE, 0, "R9");
  endtask

  task automatic t_option();
    option = 0;
    win(24'h600000, 0, "R10"); win(24'h9FFFFC, 0, "R10");
    win(24'h5FFFFE, 1, "R10"); win(24'hF80002, 1, "R10");
    option = 1;
  endtask

  task automatic t_hold();
    wr(24'h2000E0, 16'h7777, "R3");
    @(negedge clk);
    addr = 24'h2000E0; rw = 1; uds = 1; lds = 1; as = 1;
    @(negedge clk);
    chk(dtack && !mem_req, "R11", "hit ack", {dtack, mem_req}, 2'b10);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(dtack && rdata == 16'h7777, "R11", "ack held", {dtack, rdata}, {1'b1, 16'h7777});
    end
    as = 0;
    @(negedge clk);
    chk(!dtack, "R11", "ack released", dtack, 0);
  endtask

  initial begin
    #(5ns * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_enable();
    t_write_hit();
    t_read_miss();
    t_alias();
    t_byte();
    t_dma();
    t_windows();
    t_option();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule